// File: doc/BRIEF.md
# Boot-Block Flash Protection Controller

This block keeps the per-block write protection of a 32 Mbit, x16 boot-block NOR flash. A 21-bit word address is decoded into one of 71 erase blocks. The map is uneven: the lowest part of the address space holds eight small 4 KWord parameter blocks, and sixty-three 32 KWord main blocks fill the rest. For every block the controller holds a lock state. The state can be open, held, or frozen. A frozen block that has been opened while write-protect was off keeps a latent freeze mark.

A command decoder sits in front of this block. It sends lock, unlock, freeze and seal requests, together with the address they apply to, and asks whether a program or erase on that address may go ahead. The write-protect pin stops frozen blocks from being opened. A supply-lockout flag protects the whole array. A one-time seal makes parameter block 0, the security block, protected for good. When an attempt hits a protected block, the controller raises an error pulse. The array itself and the command decoding are outside this block.

Top module: `bbp_protect_ctrl`

## Requirements
- R1: Word addresses below 0x8000 fall into parameter blocks of 4096 words, where block = address / 4096. Each block's status is reached from any address inside it.
- R2: Addresses from 0x8000 up fall into main blocks of 32768 words, where block = 7 + address / 32768. The last block is 70, and it ends at 0x1FFFFF. A request never changes the block on either side of a boundary.
- R3: After reset every block reads status code 01 (held) and is protected, and the security seal is cleared.
- R4: Lock states are independent per block. Any mix of held and open blocks can exist at the same time.
- R5: A lock or unlock request changes the addressed block's state at the clock edge that samples it. The new state and the new protect flag can be read in the next cycle.
- R6: A freeze request makes the block's status 11 (held and frozen). While wp_on is 1, an unlock request on a block with the freeze mark is ignored.
- R7: While vpp_low is 1, protect_o is 1 for every address, whatever the lock state. Status codes are not changed by it.
- R8: A seal request makes every address of block 0 protected until the next reset. Unlock requests do not clear it, and no other block is affected.
- R9: With wp_on at 0, a frozen block can be unlocked and reads 10 (open, freeze mark kept) with protect_o at 0. Once wp_on returns to 1 it reads 11 again and is protected from the next cycle.
- R10: When several requests arrive in one cycle, freeze takes priority over lock, and lock takes priority over unlock.
- R11: prot_err_o is 1 in the cycle after a pgm_req whose target was protected, judged on the state before that edge. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; every block is held, and the seal is cleared |
| addr_i | input | 21 | Word address selecting the target block |
| lock_req | input | 1 | Set the held state of the addressed block |
| unlock_req | input | 1 | Clear the held state of the addressed block |
| freeze_req | input | 1 | Set the held state and the freeze mark of the addressed block |
| seal_req | input | 1 | Permanently protect block 0 (until reset) |
| pgm_req | input | 1 | Program or erase attempt on the addressed block |
| wp_on | input | 1 | Write-protect pin, active high |
| vpp_low | input | 1 | Supply below the program lockout level |
| protect_o | output | 1 | The addressed block refuses program and erase |
| lock_status_o | output | 2 | Status code of the addressed block: bit 0 is held, bit 1 is the freeze mark |
| prot_err_o | output | 1 | Registered protection-error pulse |

## Verification
Two pairs of functions can land on the same edge. The first is a program attempt together with an unlock of the same held block. The bench drives both in one cycle and expects an error pulse, because the attempt is judged on the old state, and then expects status 00 in the following cycle. The second is write-protect going back to 1 while a block carries an open freeze mark. The bench raises wp_on on a falling edge and expects status 11 and protection right after the next rising edge. In another cycle, conflicting requests are combined to confirm the priority order.

// File: rtl/bbp_pkg.sv
package bbp_pkg;

  typedef enum logic [1:0] {
    LK_OPEN   = 2'b00,
    LK_HELD   = 2'b01,
    LK_LATENT = 2'b10,
    LK_FROZEN = 2'b11
  } lk_code_t;

  // Block number of a word address: small blocks first, large ones above them.
  function automatic logic [31:0] blk_index(input logic [31:0] a,
                                            input logic [31:0] n_small,
                                            input logic [31:0] s_shift,
                                            input logic [31:0] l_shift);
    logic [31:0] small_end;
    small_end = n_small << s_shift;
    if (a < small_end) return a >> s_shift;
    return n_small + (a >> l_shift) - (small_end >> l_shift);
  endfunction

endpackage

// File: rtl/bbp_addr_decode.sv
module bbp_addr_decode
  import bbp_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int NPARAM = 8,
  parameter int PSHIFT = 12,
  parameter int MSHIFT = 15,
  parameter int IDX_W  = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              is_blk0_o
);
  logic [31:0] idx_full;

  always_comb begin
    idx_full  = blk_index(32'(addr_i), 32'(NPARAM), 32'(PSHIFT), 32'(MSHIFT));
    idx_o     = idx_full[IDX_W-1:0];
    is_blk0_o = (idx_full == 32'd0);
  end
endmodule

// File: rtl/bbp_lock_cell.sv
module bbp_lock_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_i,
  input  logic       lock_i,
  input  logic       unlock_i,
  input  logic       freeze_i,
  input  logic       wp_on,
  output logic [1:0] code_o,
  output logic       ev_unlock_blocked_o
);
  logic held_q;
  logic mark_q;
  logic unlock_ok;

  assign unlock_ok = !(mark_q && wp_on);
  assign ev_unlock_blocked_o = sel_i && unlock_i && !lock_i && !freeze_i && !unlock_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b1;
      mark_q <= 1'b0;
    end else if (sel_i && freeze_i) begin
      held_q <= 1'b1;
      mark_q <= 1'b1;
    end else if (sel_i && lock_i) begin
      held_q <= 1'b1;
    end else if (sel_i && unlock_i && unlock_ok) begin
      held_q <= 1'b0;
    end else if (mark_q && wp_on) begin
      held_q <= 1'b1;
    end
  end

  assign code_o = {mark_q, held_q};
endmodule

// File: rtl/bbp_protect_eval.sv
module bbp_protect_eval (
  input  logic [1:0] code_i,
  input  logic       wp_on,
  input  logic       vpp_low,
  input  logic       sealed_i,
  input  logic       is_blk0_i,
  output logic       protect_o
);
  logic by_lock;
  logic by_mark;
  logic by_seal;

  always_comb begin
    by_lock   = code_i[0];
    by_mark   = code_i[1] && wp_on;
    by_seal   = sealed_i && is_blk0_i;
    protect_o = by_lock || by_mark || by_seal || vpp_low;
  end
endmodule

// File: rtl/bbp_protect_ctrl.sv
module bbp_protect_ctrl #(
  parameter int ADDR_W = 21,
  parameter int NPARAM = 8,
  parameter int PSHIFT = 12,
  parameter int MSHIFT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lock_req,
  input  logic              unlock_req,
  input  logic              freeze_req,
  input  logic              seal_req,
  input  logic              pgm_req,
  input  logic              wp_on,
  input  logic              vpp_low,
  output logic              protect_o,
  output logic [1:0]        lock_status_o,
  output logic              prot_err_o
);
  localparam int NMAIN = ((1 << ADDR_W) - (NPARAM << PSHIFT)) >> MSHIFT;
  localparam int NBLK  = NPARAM + NMAIN;
  localparam int IDX_W = $clog2(NBLK);

  logic [IDX_W-1:0] sel_idx;
  logic             sel_is_blk0;
  logic [1:0]       code_arr [NBLK];
  logic [NBLK-1:0]  blocked_vec;
  logic             ev_unlock_blocked;
  logic             sealed_q;
  logic             ev_err;

  bbp_addr_decode #(
    .ADDR_W(ADDR_W), .NPARAM(NPARAM), .PSHIFT(PSHIFT), .MSHIFT(MSHIFT), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i   (addr_i),
    .idx_o    (sel_idx),
    .is_blk0_o(sel_is_blk0)
  );

  for (genvar b = 0; b < NBLK; b++) begin : g_cell
    bbp_lock_cell u_cell (
      .clk                (clk),
      .rst_n              (rst_n),
      .sel_i              (sel_idx == IDX_W'(b)),
      .lock_i             (lock_req),
      .unlock_i           (unlock_req),
      .freeze_i           (freeze_req),
      .wp_on              (wp_on),
      .code_o             (code_arr[b]),
      .ev_unlock_blocked_o(blocked_vec[b])
    );
  end

  assign lock_status_o     = code_arr[sel_idx];
  assign ev_unlock_blocked = |blocked_vec;

  bbp_protect_eval u_eval (
    .code_i   (lock_status_o),
    .wp_on    (wp_on),
    .vpp_low  (vpp_low),
    .sealed_i (sealed_q),
    .is_blk0_i(sel_is_blk0),
    .protect_o(protect_o)
  );

  assign ev_err = pgm_req && protect_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sealed_q   <= 1'b0;
      prot_err_o <= 1'b0;
    end else begin
      if (seal_req) sealed_q <= 1'b1;
      prot_err_o <= ev_err;
    end
  end
endmodule

// File: rtl/bbp_protect_chk.sv
module bbp_protect_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              lock_req,
  input logic              unlock_req,
  input logic              freeze_req,
  input logic              pgm_req,
  input logic              wp_on,
  input logic              vpp_low,
  input logic              protect_o,
  input logic [1:0]        lock_status_o,
  input logic              prot_err_o,
  input logic              ev_unlock_blocked,
  input logic              sealed_q,
  input logic              sel_is_blk0
);
  p_reset_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> lock_status_o[0]);

  p_lock_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |=> (!$stable(addr_i) || lock_status_o[0]));

  p_unlock_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_req && !lock_req && !freeze_req && !(lock_status_o[1] && wp_on))
    |=> (!$stable(addr_i) || !lock_status_o[0]));

  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unlock_blocked |=> (!$stable(addr_i) || lock_status_o == 2'b11));

  p_vpp_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_low |-> protect_o);

  p_seal_blk0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sealed_q && sel_is_blk0) |-> protect_o);

  p_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_on && lock_status_o[1] && !unlock_req) |=> (!$stable(addr_i) || lock_status_o == 2'b11));

  p_freeze_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_req |=> (!$stable(addr_i) || lock_status_o == 2'b11));

  p_err_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_req && protect_o) |=> prot_err_o);

  p_err_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_req && protect_o) |=> !prot_err_o);
endmodule

bind bbp_protect_ctrl bbp_protect_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .addr_i           (addr_i),
  .lock_req         (lock_req),
  .unlock_req       (unlock_req),
  .freeze_req       (freeze_req),
  .pgm_req          (pgm_req),
  .wp_on            (wp_on),
  .vpp_low          (vpp_low),
  .protect_o        (protect_o),
  .lock_status_o    (lock_status_o),
  .prot_err_o       (prot_err_o),
  .ev_unlock_blocked(ev_unlock_blocked),
  .sealed_q         (sealed_q),
  .sel_is_blk0      (sel_is_blk0)
);

// File: tb/bbp_protect_ctrl_tb_top.sv
`timescale 1ns/1ps
module bbp_protect_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] addr = '0;
  logic        lock_r = 0, unlock_r = 0, freeze_r = 0, seal_r = 0, pgm_r = 0;
  logic        wp = 0, vpp = 0;
  logic        prot;
  logic [1:0]  st;
  logic        err;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  bbp_protect_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr),
    .lock_req(lock_r), .unlock_req(unlock_r), .freeze_req(freeze_r),
    .seal_req(seal_r), .pgm_req(pgm_r), .wp_on(wp), .vpp_low(vpp),
    .protect_o(prot), .lock_status_o(st), .prot_err_o(err)
  );

  function automatic int bstart(input int b);
    return (b < 8) ? b * 4096 : 32768 * (b - 7);
  endfunction
  function automatic int bend(input int b);
    return bstart(b) + ((b < 8) ? 4095 : 32767);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d (addr %h)", req, got, exp, addr);
    end
  endtask

  task automatic peek(input int a);
    addr = 21'(a);
    #1;
  endtask

  task automatic op(input int a, input logic l, input logic u, input logic f,
                    input logic s, input logic p);
    @(negedge clk);
    addr = 21'(a); lock_r = l; unlock_r = u; freeze_r = f; seal_r = s; pgm_r = p;
    @(posedge clk);
    #1;
    lock_r = 0; unlock_r = 0; freeze_r = 0; seal_r = 0; pgm_r = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R3: all held after reset
    for (int b = 0; b < 71; b++) begin
      peek(bend(b)); chk("R3 status", st, 1); chk("R3 protect", prot, 1);
    end
    chk("R11 idle err", err, 0);
    // R1/R2: open block by block through its first word, check its last word and the next block
    for (int b = 0; b < 71; b++) begin
      op(bstart(b), 0, 1, 0, 0, 0);
      peek(bend(b)); chk(b < 8 ? "R1 open" : "R2 open", st, 0);
      chk("R5 protect off", prot, 0);
      if (b < 70) begin
        peek(bstart(b + 1)); chk("R2 neighbour held", st, 1);
      end
    end
    // R7: lockout covers all
    @(negedge clk); vpp = 1; #1;
    for (int b = 0; b < 71; b += 7) begin
      peek(bstart(b) + 5); chk("R7 protect", prot, 1); chk("R7 status kept", st, 0);
    end
    @(negedge clk); vpp = 0; #1;
    peek(bstart(3)); chk("R7 release", prot, 0);
    // R5/R4: lock one, neighbours untouched
    op(bstart(30) + 1000, 1, 0, 0, 0, 0);
    peek(bend(30)); chk("R5 lock", st, 1); chk("R5 lock protect", prot, 1);
    peek(bend(29)); chk("R4 left open", st, 0);
    peek(bstart(31)); chk("R4 right open", st, 0);
    // R6: freeze under write-protect
    @(negedge clk); wp = 1;
    op(bstart(9), 0, 0, 1, 0, 0);
    peek(bstart(9)); chk("R6 frozen", st, 3);
    op(bstart(9) + 7, 0, 1, 0, 0, 0);
    peek(bstart(9)); chk("R6 unlock ignored", st, 3); chk("R6 protect", prot, 1);
    // R9: wp off allows unlock, wp back refreezes
    @(negedge clk); wp = 0;
    op(bstart(9), 0, 1, 0, 0, 0);
    peek(bstart(9)); chk("R9 latent", st, 2); chk("R9 open protect", prot, 0);
    @(negedge clk); wp = 1;
    @(posedge clk); #1;
    peek(bstart(9)); chk("R9 fallback", st, 3); chk("R9 fallback protect", prot, 1);
    @(negedge clk); wp = 0;
    // R10: priority
    op(bstart(40), 1, 1, 0, 0, 0);
    peek(bstart(40)); chk("R10 lock over unlock", st, 1);
    op(bstart(41), 1, 1, 1, 0, 0);
    peek(bstart(41)); chk("R10 freeze wins", st, 3);
    // R11: error pulse
    op(bstart(50), 0, 0, 0, 0, 1);
    chk("R11 open no err", err, 0);
    op(bstart(30), 0, 0, 0, 0, 1);
    chk("R11 held err", err, 1);
    op(bstart(30), 0, 1, 0, 0, 1);
    chk("R11 err on old state", err, 1);
    peek(bstart(30)); chk("R5 unlock same cycle", st, 0);
    op(bstart(30), 0, 0, 0, 0, 1);
    chk("R11 no err after unlock", err, 0);
    op(bstart(30), 0, 0, 0, 0, 0);
    chk("R11 err drops", err, 0);
    // R8: seal
    op(100, 0, 0, 0, 1, 0);
    peek(bend(0)); chk("R8 sealed", prot, 1); chk("R8 status kept", st, 0);
    peek(bstart(1)); chk("R8 block1 free", prot, 0);
    op(0, 0, 1, 0, 0, 0);
    peek(bstart(0)); chk("R8 survives unlock", prot, 1);
    op(bstart(0), 0, 0, 0, 0, 1);
    chk("R8 sealed err", err, 1);
    // R3: reset again clears freeze and seal
    do_reset();
    peek(bstart(9)); chk("R3 freeze cleared", st, 1);
    op(bstart(0), 0, 1, 0, 0, 0);
    peek(bstart(0)); chk("R3 seal cleared", prot, 0);
    chk("R3 err cleared", err, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule